// File: doc/BRIEF.md
# 16550-Style UART Transmitter with Banked Register Interface

This block is the transmit half of a byte-wide, register-mapped serial port that software drives through the classic 16550 programming model. A small bus port carries a 3-bit offset, separate read and write strobes, and 8-bit write and read data. Through it, software sets the line format, loads a 16-bit baud divisor, turns the transmit queue on, off or clears it, and pushes characters. The block then serializes them onto a single TX line.

Some offsets are banked. The divisor latch access bit in the line control register decides whether offsets 0 and 1 reach the divisor bytes or the holding and interrupt-enable registers. Offset 0 also behaves differently for reads and writes. A write queues a character, and a read returns the unimplemented receive holding register as zero.

A free-running counter divides the clock by the divisor to make a tick at 16 times the bit rate. The serializer holds each bit for 16 ticks. Software normally polls the status register for room in the queue before writing the next character.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the TX line is high, the status register at offset 5 reads 0x60, and every other offset reads 0x00.
- R2: Bit 7 of the line control register is the divisor latch access bit. When it is set, offsets 0 and 1 write and read back the divisor low and high bytes. When it is clear, a write to offset 0 queues a character, a read of offset 0 returns 0x00, and offset 1 writes and reads back the interrupt enable register without touching the divisor.
- R3: The line control register at offset 3 reads back as written. Its bits 1:0 pick 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3, and the character is sent with its upper bits dropped.
- R4: Each frame has a low start bit, then the data bits LSB first, then one high stop bit. The line idles high.
- R5: Every bit lasts exactly 16 times the divisor clock cycles. An all-zero 8-bit character therefore holds the line low for 9*16*divisor cycles.
- R6: While the divisor is zero, no frame starts and the TX line stays high even with characters queued. Writing a divisor byte restarts the tick counter, and queued characters then go out.
- R7: Offset 2 is write-only and reads 0x00. Bit 0 turns the queue on. Bit 2 empties the transmit queue. Bit 1 has no effect on the transmit side.
- R8: With the queue on, up to 16 characters are held and sent in order. A write while 16 are held is dropped.
- R9: With the queue off, only one character is held. A second write made before it leaves is dropped.
- R10: Status bit 5 is set while the queue can take another character. Status bit 6 is set when the queue is empty and no frame is in progress. All other status bits read 0. So 0x60 means idle, 0x20 means there is room but work is pending, and 0x00 means full.
- R11: Emptying the queue during a frame does not cut that frame short. The characters that were still queued are never sent.
- R12: While the read strobe is low, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle the read strobe is high |
| tx_out | output | 1 | Serial transmit line |

## Verification
The bench builds the block with its default 16-entry queue and 16-bit divisor. It programs divisors of 0, 1, 2 and 3 at run time. A zero divisor freezes the line, so the queue can be filled to its limit and past it before any character drains, which brings the dropped seventeenth write and the single-entry mode into reach. Divisors 2 and 3 make the low-run length depend on the divisor, which exposes an off-by-one in bit timing. Divisor 1 keeps the 16-frame drain and the random batches of mixed word lengths short.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned BYTE_W = 8;

    // register offsets
    localparam logic [2:0] OFS_HOLD = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_FCR  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_LSR  = 3'd5;

    // bit positions software depends on
    localparam int unsigned FCR_EN_BIT    = 0;
    localparam int unsigned FCR_TXCLR_BIT = 2;
    localparam int unsigned LSR_THRE_BIT  = 5;
    localparam int unsigned LSR_TEMT_BIT  = 6;

    // 16 baud ticks per bit
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned SUB_W      = $clog2(OVERSAMPLE);

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP
    } shift_state_e;

    typedef struct packed {
        logic       dlab;
        logic [4:0] frame_rsvd;
        logic [1:0] wlen;
    } line_ctrl_t;

    typedef struct packed {
        logic thre;
        logic temt;
    } tx_flags_t;

    function automatic logic [3:0] data_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    function automatic logic [7:0] status_byte(input tx_flags_t f);
        logic [7:0] s;
        s = '0;
        s[LSR_THRE_BIT] = f.thre;
        s[LSR_TEMT_BIT] = f.temt;
        return s;
    endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] phase;
    logic             run;

    assign run  = (divisor != '0);
    assign tick = run && (phase == divisor - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + DIV_W'(1);
        end
    end

    // R5: the phase counter never passes the divisor, so the tick period is exact
    a_r5_phase_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> (phase < divisor));

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         single,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = single ? (count != '0) : (count == CNT_W'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R8: occupancy never exceeds the storage
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R8: a write into a full queue is dropped
    a_r8_full_drops: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (count == $past(count)));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         avail,
    input  logic [W-1:0] data_in,
    input  logic [1:0]   wlen,
    output logic         take,
    output logic         busy,
    output logic         tx
);

    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

    shift_state_e     state;
    logic [SUB_W-1:0] sub;
    logic [IDX_W-1:0] idx;
    logic [3:0]       nbits;
    logic [W-1:0]     shreg;
    logic             bit_end;

    assign take    = (state == SH_IDLE) && tick && avail;
    assign busy    = (state != SH_IDLE);
    assign bit_end = tick && (sub == SUB_W'(OVERSAMPLE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            sub   <= '0;
            idx   <= '0;
            nbits <= '0;
            shreg <= '0;
        end else if (state == SH_IDLE) begin
            if (take) begin
                shreg <= data_in;
                nbits <= data_bits(wlen);
                sub   <= '0;
                state <= SH_START;
            end
        end else if (tick) begin
            sub <= sub + SUB_W'(1);
            if (bit_end) begin
                case (state)
                    SH_START: begin
                        idx   <= '0;
                        state <= SH_DATA;
                    end
                    SH_DATA: begin
                        shreg <= shreg >> 1;
                        idx   <= idx + IDX_W'(1);
                        if (32'(idx) + 32'd1 == 32'(nbits)) state <= SH_STOP;
                    end
                    default: state <= SH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            SH_START: tx = 1'b0;
            SH_DATA:  tx = shreg[0];
            default:  tx = 1'b1;
        endcase
    end

    // R5: the line can only move on a baud tick
    a_r5_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tx));

    // R4: taking a character drives the start bit low
    a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
        take |=> !tx);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       tx_out
);

    localparam int unsigned DIV_W = 2 * BYTE_W;

    line_ctrl_t        lcr;
    logic [BYTE_W-1:0] ier, dll, dlm;
    logic              fifo_en;
    logic [DIV_W-1:0]  divisor;
    logic              dlab;

    logic              hold_push, tx_clear, div_restart;
    logic              baud_tick;
    logic              q_empty, q_full, sh_take, sh_busy;
    logic [BYTE_W-1:0] q_data;
    tx_flags_t         flags;

    assign dlab    = lcr.dlab;
    assign divisor = {dlm, dll};

    // write side effects that act in the same cycle
    always_comb begin
        hold_push   = wr_en && (addr == OFS_HOLD) && !dlab;
        tx_clear    = wr_en && (addr == OFS_FCR) && wdata[FCR_TXCLR_BIT];
        div_restart = wr_en && dlab && ((addr == OFS_HOLD) || (addr == OFS_IER));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr     <= '0;
            ier     <= '0;
            dll     <= '0;
            dlm     <= '0;
            fifo_en <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFS_HOLD: if (dlab) dll <= wdata;
                OFS_IER:  if (dlab) dlm <= wdata; else ier <= wdata;
                OFS_FCR:  fifo_en <= wdata[FCR_EN_BIT];
                OFS_LCR:  lcr <= line_ctrl_t'(wdata);
                default:  ;
            endcase
        end
    end

    uart_baud_tick #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .restart (div_restart),
        .tick    (baud_tick)
    );

    uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .clr    (tx_clear),
        .single (!fifo_en),
        .push   (hold_push),
        .wdata  (wdata),
        .pop    (sh_take),
        .rdata  (q_data),
        .empty  (q_empty),
        .full   (q_full)
    );

    uart_tx_shifter #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .avail   (!q_empty),
        .data_in (q_data),
        .wlen    (lcr.wlen),
        .take    (sh_take),
        .busy    (sh_busy),
        .tx      (tx_out)
    );

    assign flags.thre = !q_full;
    assign flags.temt = q_empty && !sh_busy;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_HOLD: rdata = dlab ? dll : '0;
                OFS_IER:  rdata = dlab ? dlm : ier;
                OFS_LCR:  rdata = lcr;
                OFS_LSR:  rdata = status_byte(flags);
                default:  rdata = '0;
            endcase
        end
    end

    // R6: a stopped divisor keeps an idle line high
    a_r6_stopped_line_high: assert property (@(posedge clk) disable iff (rst)
        ((divisor == '0) && !sh_busy) |=> tx_out);

    // R11: emptying the queue does not end a frame in progress
    a_r11_clear_keeps_frame: assert property (@(posedge clk) disable iff (rst)
        (tx_clear && sh_busy && !baud_tick) |=> sh_busy);

endmodule

// File: tb/tb_uart_tx_core.sv
`timescale 1ns/1ps
module tb_uart_tx_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_tx_core dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .tx_out(tx_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        chk(req, {24'd0, v}, {24'd0, exp});
    endtask

    // program divisor with high byte first, leave LCR at the given word length
    task automatic set_div(input logic [15:0] d, input logic [1:0] wl);
        bus_wr(3'd3, {1'b1, 5'd0, wl});
        bus_wr(3'd1, d[15:8]);
        bus_wr(3'd0, d[7:0]);
        bus_wr(3'd3, {6'd0, wl});
    endtask

    function automatic logic [7:0] wmask(input int wl, input logic [7:0] b);
        return b & 8'((1 << (5 + wl)) - 1);
    endfunction

    task automatic rx_frame(input int nbits, input int div, output logic [7:0] d);
        d = '0;
        while (tx_out !== 1'b0) @(negedge clk);
        repeat (8 * div) @(negedge clk);
        chk("R4 start bit", {31'd0, tx_out}, 32'd0);
        for (int k = 0; k < nbits; k++) begin
            repeat (16 * div) @(negedge clk);
            d[k] = tx_out;
        end
        repeat (16 * div) @(negedge clk);
        chk("R4 stop bit", {31'd0, tx_out}, 32'd1);
    endtask

    task automatic quiet(input int n, input string req);
        int lows;
        lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (tx_out !== 1'b1) lows++;
        end
        chk(req, lows, 0);
    endtask

    task automatic low_run(input int exp_len, input string req);
        int len;
        len = 0;
        while (tx_out !== 1'b0) @(negedge clk);
        while (tx_out === 1'b0) begin
            len++;
            @(negedge clk);
        end
        chk(req, len, exp_len);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got, b;
        logic [7:0] q [16];
        int wl, n;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx idle", {31'd0, tx_out}, 32'd1);
        rd_chk("R1 status", 3'd5, 8'h60);
        rd_chk("R1 lcr", 3'd3, 8'h00);
        rd_chk("R1 ier", 3'd1, 8'h00);
        rd_chk("R1 offset0", 3'd0, 8'h00);
        rd_chk("R1 offset7", 3'd7, 8'h00);

        // R12 read strobe low gives zero
        @(negedge clk);
        addr = 3'd5; rd_en = 1'b0;
        #1 chk("R12 rdata without strobe", {24'd0, rdata}, 32'd0);

        // R2 banking
        bus_wr(3'd3, 8'h80);
        bus_wr(3'd0, 8'h5A);
        bus_wr(3'd1, 8'hC3);
        rd_chk("R2 divisor low", 3'd0, 8'h5A);
        rd_chk("R2 divisor high", 3'd1, 8'hC3);
        bus_wr(3'd3, 8'h03);
        bus_wr(3'd1, 8'h0A);
        rd_chk("R2 ier readback", 3'd1, 8'h0A);
        rd_chk("R2 rhr reads zero", 3'd0, 8'h00);
        bus_wr(3'd3, 8'h83);
        rd_chk("R2 divisor high kept", 3'd1, 8'hC3);
        rd_chk("R3 lcr readback", 3'd3, 8'h83);

        // R8 fill past capacity with a stopped divisor
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd3, 8'h03);
        bus_wr(3'd2, 8'h01);
        rd_chk("R7 fcr reads zero", 3'd2, 8'h00);
        for (int i = 0; i < 17; i++) begin
            b = 8'($urandom);
            if (i < 16) q[i] = b;
            bus_wr(3'd0, b);
            if (i == 0) rd_chk("R10 room with work pending", 3'd5, 8'h20);
        end
        rd_chk("R10 full status", 3'd5, 8'h00);
        quiet(40, "R6 stopped divisor holds line high");
        set_div(16'd1, 2'd3);
        for (int i = 0; i < 16; i++) begin
            rx_frame(8, 1, got);
            chk("R8 fifo order", {24'd0, got}, {24'd0, q[i]});
        end
        quiet(60, "R8 dropped write never sent");
        rd_chk("R10 idle status", 3'd5, 8'h60);

        // R3 word lengths
        for (int w = 0; w < 4; w++) begin
            b = 8'($urandom);
            bus_wr(3'd3, 8'(w));
            bus_wr(3'd0, b);
            rx_frame(5 + w, 1, got);
            chk("R3 word length data", {24'd0, got}, {24'd0, wmask(w, b)});
        end

        // R5 bit timing for two divisors
        set_div(16'd2, 2'd3);
        bus_wr(3'd0, 8'h00);
        low_run(9 * 16 * 2, "R5 low run divisor 2");
        repeat (40) @(negedge clk);
        set_div(16'd3, 2'd3);
        bus_wr(3'd0, 8'h00);
        low_run(9 * 16 * 3, "R5 low run divisor 3");
        repeat (60) @(negedge clk);

        // R9 single holding register
        set_div(16'd0, 2'd3);
        bus_wr(3'd2, 8'h00);
        bus_wr(3'd0, 8'hA5);
        rd_chk("R9 single entry full", 3'd5, 8'h00);
        bus_wr(3'd0, 8'h3C);
        set_div(16'd1, 2'd3);
        rx_frame(8, 1, got);
        chk("R9 first byte sent", {24'd0, got}, 32'hA5);
        quiet(60, "R9 second write dropped");

        // R7 clear command, bit 1 has no effect
        set_div(16'd0, 2'd3);
        bus_wr(3'd2, 8'h01);
        bus_wr(3'd0, 8'h11);
        bus_wr(3'd0, 8'h22);
        bus_wr(3'd0, 8'h33);
        bus_wr(3'd2, 8'h03);
        rd_chk("R7 bit1 leaves queue", 3'd5, 8'h20);
        bus_wr(3'd2, 8'h05);
        rd_chk("R7 clear empties queue", 3'd5, 8'h60);
        set_div(16'd1, 2'd3);
        quiet(60, "R7 cleared bytes not sent");

        // R11 clear during a frame
        set_div(16'd2, 2'd3);
        bus_wr(3'd0, 8'h96);
        bus_wr(3'd0, 8'h69);
        while (tx_out !== 1'b0) @(negedge clk);
        bus_wr(3'd2, 8'h05);
        rd_chk("R10 busy with empty queue", 3'd5, 8'h20);
        rx_frame(8, 2, got);
        chk("R11 frame completes", {24'd0, got}, 32'h96);
        quiet(120, "R11 queued byte discarded");
        rd_chk("R11 idle after frame", 3'd5, 8'h60);

        // random batches with mixed word lengths
        for (int bt = 0; bt < 3; bt++) begin
            wl = int'($urandom_range(0, 3));
            n = int'($urandom_range(1, 16));
            set_div(16'd0, 2'(wl));
            for (int i = 0; i < n; i++) begin
                q[i] = 8'($urandom);
                bus_wr(3'd0, q[i]);
            end
            set_div(16'd1, 2'(wl));
            for (int i = 0; i < n; i++) begin
                rx_frame(5 + wl, 1, got);
                chk("R3 R8 random batch", {24'd0, got}, {24'd0, wmask(wl, q[i])});
            end
            repeat (40) @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule